// File: doc/BRIEF.md
# Key Slot Policy Enforcement Unit

This block sits inside a security domain and stands guard over a bank of cryptographic key slots. A requester names a key only by its slot number and never sees the key value. Each request asks for one operation: encrypt, decrypt, MAC generation, MAC verification, import, update or export. The unit weighs that operation against three things: the slot's stored permission flags, whether the slot holds a key, and the lifecycle state supplied from outside. It then answers with a grant, or with a denial and a 3-bit reason.

A granted use or export places the slot's key on an internal port that feeds the crypto engines, tagged with the operation. A granted import or update writes the new key and its flags into the slot. Proof that an updater knows the current key, or a designated update key, comes from an external verifier as a single flag. Requests use a valid/ready handshake. The response and the internal key port are both registered and appear one cycle after the request is accepted.

Top module: `keyslot_guard`

## Requirements
- R1: After reset, rsp_valid and core_valid are low, core_key is zero, and every slot is empty. A use request on any slot is denied with reason 1 (empty).
- R2: The key value appears only on core_key, and only in the cycle that core_valid is high. In every other cycle core_key is zero, including after import and update grants and after any denial.
- R3: The use operations are encrypt (op 0), decrypt (op 1), MAC generate (op 2) and MAC verify (op 3). They are granted only on a populated slot whose matching flag bit is set: bit 0 for encrypt, bit 1 for decrypt, bit 2 for MAC generate and bit 3 for MAC verify. A grant raises core_valid with core_op equal to the request op and core_key equal to the stored key. An empty slot gives reason 1, and a missing flag gives reason 2 (attribute).
- R4: A slot with bit 3 set and bit 2 clear is verify-only. MAC verification on it is granted and MAC generation is denied with reason 2.
- R5: Import (op 4) is granted only into an empty slot that carries its import flag (bit 4, set at reset for slots in IMPORT_SLOT_MASK) while IMPORT_LC_MASK[lc_state] is 1. A populated slot, or a slot without the flag, gives reason 2. Otherwise a forbidden lifecycle gives reason 3. A grant stores req_key and req_attr and marks the slot populated.
- R6: Update (op 5) of a populated slot needs flag bit 5 and req_proof high. If proof is missing the request is denied with reason 4. If granted, the key and flags are replaced, and a use accepted in the very next cycle already sees the new key.
- R7: Export (op 6) with req_wrapped low is always denied with reason 5 (plaintext). This check comes before every other check, including the check for an empty slot.
- R8: A wrapped export needs export flag bit 6 and export lock bit 7 clear. A set lock gives reason 2 whatever bit 6 says. A grant drives the key to core_key with core_op 6.
- R9: A denied request changes neither the key nor the flags nor the populated state of any slot.
- R10: The export lock bit survives an update: the new flags are req_attr with bit 7 ORed in from the old flags.
- R11: Each accepted request produces rsp_valid for exactly one cycle, one cycle after acceptance. rsp_grant high always comes with reason 0, and a denial always comes with a non-zero reason.
- R12: Reserved op 7 is denied with reason 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 3 | Operation code |
| req_slot | input | ID_W | Slot identifier |
| req_wrapped | input | 1 | Export asked in protected form |
| req_proof | input | 1 | Proof-of-knowledge flag from verifier |
| req_key | input | KEY_W | New key for import or update |
| req_attr | input | 8 | New flags for import or update |
| lc_state | input | LC_W | Current lifecycle state |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Request granted |
| rsp_reason | output | 3 | Denial reason, 0 on grant |
| core_valid | output | 1 | Key handed to crypto engines |
| core_op | output | 3 | Operation for the crypto engines |
| core_key | output | KEY_W | Key bits for the crypto engines |

## Verification
Two functions can meet in consecutive cycles: a slot write from a granted update, and a key read from the following use of the same slot. The bench issues an update and an encrypt to the same slot on back-to-back cycles, with no idle cycle between them. It then expects the encrypt to carry the new key. A second meeting point is an update that tries to drop the export lock. The write path and the lock rule act together in that case, so the bench attempts a wrapped export afterwards and expects it to be refused.

// File: rtl/ksg_pkg.sv
package ksg_pkg;
  typedef enum logic [2:0] {
    OP_ENC    = 3'd0,
    OP_DEC    = 3'd1,
    OP_MGEN   = 3'd2,
    OP_MVER   = 3'd3,
    OP_IMPORT = 3'd4,
    OP_UPDATE = 3'd5,
    OP_EXPORT = 3'd6,
    OP_RSVD   = 3'd7
  } ksg_op_e;

  typedef enum logic [2:0] {
    RC_OK    = 3'd0,
    RC_EMPTY = 3'd1,
    RC_ATTR  = 3'd2,
    RC_LCYC  = 3'd3,
    RC_PROOF = 3'd4,
    RC_PLAIN = 3'd5
  } ksg_rc_e;

  localparam int ATTR_W  = 8;
  localparam int A_ENC   = 0;
  localparam int A_DEC   = 1;
  localparam int A_MGEN  = 2;
  localparam int A_MVER  = 3;
  localparam int A_IMP   = 4;
  localparam int A_UPD   = 5;
  localparam int A_EXP   = 6;
  localparam int A_LOCK  = 7;
endpackage

// File: rtl/ksg_slot_bank.sv
module ksg_slot_bank
  import ksg_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int KEY_W = 256,
  parameter int ID_W = 4,
  parameter logic [NUM_SLOTS-1:0] IMPORT_SLOT_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   rd_slot,
  output logic              rd_in_range,
  output logic              rd_valid,
  output logic [ATTR_W-1:0] rd_attr,
  output logic [KEY_W-1:0]  rd_key,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_slot,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [ATTR_W-1:0] wr_attr
);
  logic [KEY_W-1:0]  key_arr  [NUM_SLOTS];
  logic [ATTR_W-1:0] attr_arr [NUM_SLOTS];
  logic              vld_arr  [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [ATTR_W-1:0] RST_ATTR = ATTR_W'(IMPORT_SLOT_MASK[s]) << A_IMP;
    logic              sel;
    logic [KEY_W-1:0]  key_q, key_d;
    logic [ATTR_W-1:0] attr_q, attr_d;
    logic              vld_q, vld_d;

    assign sel = wr_en && (wr_slot == ID_W'(s));

    always_comb begin
      key_d  = key_q;
      attr_d = attr_q;
      vld_d  = vld_q;
      if (sel) begin
        key_d  = wr_key;
        attr_d = wr_attr;
        vld_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        key_q  <= '0;
        attr_q <= RST_ATTR;
        vld_q  <= 1'b0;
      end else if (sel) begin
        key_q  <= key_d;
        attr_q <= attr_d;
        vld_q  <= vld_d;
      end
    end

    assign key_arr[s]  = key_q;
    assign attr_arr[s] = attr_q;
    assign vld_arr[s]  = vld_q;
  end

  always_comb begin
    rd_in_range = (int'(rd_slot) < NUM_SLOTS);
    rd_valid    = 1'b0;
    rd_attr     = '0;
    rd_key      = '0;
    if (rd_in_range) begin
      rd_valid = vld_arr[rd_slot];
      rd_attr  = attr_arr[rd_slot];
      rd_key   = key_arr[rd_slot];
    end
  end
endmodule

// File: rtl/ksg_policy.sv
module ksg_policy
  import ksg_pkg::*;
#(
  parameter int LC_W = 2,
  parameter logic [(1<<LC_W)-1:0] IMPORT_LC_MASK = '1
) (
  input  logic [2:0]        op,
  input  logic              in_range,
  input  logic              populated,
  input  logic [ATTR_W-1:0] attr,
  input  logic              wrapped,
  input  logic              proof,
  input  logic [LC_W-1:0]   lc_state,
  output logic              grant,
  output logic [2:0]        reason,
  output logic              write_slot,
  output logic              drive_key
);
  ksg_op_e op_e;
  ksg_rc_e rc;
  logic    use_bit;

  assign op_e = ksg_op_e'(op);

  always_comb begin
    case (op_e)
      OP_ENC:  use_bit = attr[A_ENC];
      OP_DEC:  use_bit = attr[A_DEC];
      OP_MGEN: use_bit = attr[A_MGEN];
      OP_MVER: use_bit = attr[A_MVER];
      default: use_bit = 1'b0;
    endcase
  end

  always_comb begin
    rc         = RC_OK;
    write_slot = 1'b0;
    drive_key  = 1'b0;
    if (op_e == OP_EXPORT && !wrapped) begin
      rc = RC_PLAIN;
    end else if (op_e == OP_IMPORT) begin
      if (!in_range || populated || !attr[A_IMP]) rc = RC_ATTR;
      else if (!IMPORT_LC_MASK[lc_state])         rc = RC_LCYC;
      else                                        write_slot = 1'b1;
    end else if (op_e == OP_RSVD) begin
      rc = RC_ATTR;
    end else if (!in_range || !populated) begin
      rc = RC_EMPTY;
    end else begin
      case (op_e)
        OP_UPDATE: begin
          if (!attr[A_UPD])  rc = RC_ATTR;
          else if (!proof)   rc = RC_PROOF;
          else               write_slot = 1'b1;
        end
        OP_EXPORT: begin
          if (attr[A_LOCK] || !attr[A_EXP]) rc = RC_ATTR;
          else                              drive_key = 1'b1;
        end
        default: begin
          if (!use_bit) rc = RC_ATTR;
          else          drive_key = 1'b1;
        end
      endcase
    end
  end

  assign grant  = (rc == RC_OK);
  assign reason = rc;
endmodule

// File: rtl/ksg_resp.sv
module ksg_resp #(
  parameter int KEY_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             grant,
  input  logic [2:0]       reason,
  input  logic [2:0]       op,
  input  logic             drive_key,
  input  logic [KEY_W-1:0] key,
  output logic             ready,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic [2:0]       rsp_reason,
  output logic             core_valid,
  output logic [2:0]       core_op,
  output logic [KEY_W-1:0] core_key
);
  logic             rv_d, rg_d, cv_d;
  logic [2:0]       rr_d, co_d;
  logic [KEY_W-1:0] ck_d;

  always_comb begin
    rv_d = fire;
    rg_d = fire && grant;
    rr_d = fire ? reason : 3'd0;
    cv_d = fire && drive_key;
    co_d = cv_d ? op : 3'd0;
    ck_d = cv_d ? key : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_grant  <= 1'b0;
      rsp_reason <= 3'd0;
      core_valid <= 1'b0;
      core_op    <= 3'd0;
      core_key   <= '0;
    end else begin
      ready      <= 1'b1;
      rsp_valid  <= rv_d;
      rsp_grant  <= rg_d;
      rsp_reason <= rr_d;
      core_valid <= cv_d;
      core_op    <= co_d;
      core_key   <= ck_d;
    end
  end
endmodule

// File: rtl/keyslot_guard.sv
module keyslot_guard
  import ksg_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int KEY_W = 256,
  parameter int LC_W = 2,
  parameter logic [(1<<LC_W)-1:0] IMPORT_LC_MASK = 4'b0011,
  parameter logic [NUM_SLOTS-1:0] IMPORT_SLOT_MASK = 16'h7FFF,
  localparam int ID_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [ID_W-1:0]  req_slot,
  input  logic             req_wrapped,
  input  logic             req_proof,
  input  logic [KEY_W-1:0] req_key,
  input  logic [7:0]       req_attr,
  input  logic [LC_W-1:0]  lc_state,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic [2:0]       rsp_reason,
  output logic             core_valid,
  output logic [2:0]       core_op,
  output logic [KEY_W-1:0] core_key
);
  logic              rst_sync1, rst_sync_n;
  logic              fire;
  logic              in_range, populated;
  logic [ATTR_W-1:0] cur_attr, new_attr;
  logic [KEY_W-1:0]  cur_key;
  logic              pol_grant, pol_write, pol_drive;
  logic [2:0]        pol_reason;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync1  <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_sync1  <= 1'b1;
      rst_sync_n <= rst_sync1;
    end
  end

  assign fire = req_valid && req_ready;

  ksg_slot_bank #(
    .NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W), .ID_W(ID_W),
    .IMPORT_SLOT_MASK(IMPORT_SLOT_MASK)
  ) u_bank (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_slot(req_slot), .rd_in_range(in_range), .rd_valid(populated),
    .rd_attr(cur_attr), .rd_key(cur_key),
    .wr_en(fire && pol_write), .wr_slot(req_slot),
    .wr_key(req_key), .wr_attr(new_attr)
  );

  ksg_policy #(.LC_W(LC_W), .IMPORT_LC_MASK(IMPORT_LC_MASK)) u_pol (
    .op(req_op), .in_range(in_range), .populated(populated), .attr(cur_attr),
    .wrapped(req_wrapped), .proof(req_proof), .lc_state(lc_state),
    .grant(pol_grant), .reason(pol_reason),
    .write_slot(pol_write), .drive_key(pol_drive)
  );

  always_comb begin
    new_attr = req_attr;
    if (ksg_op_e'(req_op) == OP_UPDATE) new_attr[A_LOCK] = req_attr[A_LOCK] | cur_attr[A_LOCK];
  end

  ksg_resp #(.KEY_W(KEY_W)) u_resp (
    .clk(clk), .rst_n(rst_sync_n), .fire(fire),
    .grant(pol_grant), .reason(pol_reason), .op(req_op),
    .drive_key(pol_drive), .key(cur_key),
    .ready(req_ready), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .rsp_reason(rsp_reason), .core_valid(core_valid), .core_op(core_op),
    .core_key(core_key)
  );
endmodule

// File: rtl/ksg_chk.sv
module ksg_chk #(
  parameter int KEY_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_op,
  input logic             req_wrapped,
  input logic             req_proof,
  input logic             rsp_valid,
  input logic             rsp_grant,
  input logic [2:0]       rsp_reason,
  input logic             core_valid,
  input logic [KEY_W-1:0] core_key
);
  logic fire;
  assign fire = req_valid && req_ready;

  // R11
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);
  // R11
  grant_reason_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |-> rsp_reason == 3'd0);
  // R11
  deny_reason_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> rsp_reason != 3'd0);
  // R2
  key_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_valid |-> core_key == '0);
  // R3
  core_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> (rsp_valid && rsp_grant));
  // R7
  plain_export_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_op == 3'd6 && !req_wrapped) |=> (!rsp_grant && rsp_reason == 3'd5));
  // R6
  update_proof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_op == 3'd5 && !req_proof) |=> !rsp_grant);
  // R12
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_op == 3'd7) |=> (!rsp_grant && rsp_reason == 3'd2));
endmodule

bind keyslot_guard ksg_chk #(.KEY_W(KEY_W)) u_ksg_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_wrapped(req_wrapped), .req_proof(req_proof),
  .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reason(rsp_reason),
  .core_valid(core_valid), .core_key(core_key)
);

// File: tb/test_keyslot_guard.sv
`timescale 1ns/1ps
module test_keyslot_guard;
  localparam int KEY_W = 256;
  localparam int ID_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [2:0]       req_op = '0;
  logic [ID_W-1:0]  req_slot = '0;
  logic             req_wrapped = 1'b0;
  logic             req_proof = 1'b0;
  logic [KEY_W-1:0] req_key = '0;
  logic [7:0]       req_attr = '0;
  logic [1:0]       lc_state = '0;
  logic             rsp_valid, rsp_grant, core_valid;
  logic [2:0]       rsp_reason, core_op;
  logic [KEY_W-1:0] core_key;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic             s_rv, s_g, s_cv;
  logic [2:0]       s_rr, s_co;
  logic [KEY_W-1:0] s_ck;

  localparam logic [KEY_W-1:0] K1 = {8{32'hA5A5_0001}};
  localparam logic [KEY_W-1:0] K2 = {8{32'h5A5A_0002}};
  localparam logic [KEY_W-1:0] K3 = {8{32'hC3C3_0003}};
  localparam logic [KEY_W-1:0] K4 = {8{32'h3C3C_0004}};

  always #2.5 clk = ~clk;

  keyslot_guard i_keyslot_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_slot(req_slot), .req_wrapped(req_wrapped),
    .req_proof(req_proof), .req_key(req_key), .req_attr(req_attr),
    .lc_state(lc_state), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .rsp_reason(rsp_reason), .core_valid(core_valid), .core_op(core_op),
    .core_key(core_key)
  );

  task automatic chk(input bit ok, input string req, input logic [KEY_W-1:0] act,
                     input logic [KEY_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample();
    s_rv = rsp_valid; s_g = rsp_grant; s_rr = rsp_reason;
    s_cv = core_valid; s_co = core_op; s_ck = core_key;
  endtask

  task automatic put(input logic [2:0] op, input int slot, input bit wrp, input bit prf,
                     input logic [KEY_W-1:0] key, input logic [7:0] attr);
    req_valid = 1'b1; req_op = op; req_slot = ID_W'(slot); req_wrapped = wrp;
    req_proof = prf; req_key = key; req_attr = attr;
  endtask

  task automatic issue(input logic [2:0] op, input int slot, input bit wrp, input bit prf,
                       input logic [KEY_W-1:0] key, input logic [7:0] attr);
    @(negedge clk);
    put(op, slot, wrp, prf, key, attr);
    @(negedge clk);
    req_valid = 1'b0;
    sample();
  endtask

  task automatic expect_rsp(input string req, input bit g, input logic [2:0] rc);
    chk(s_rv && s_g == g && s_rr == rc, req, KEY_W'({s_rv, s_g, s_rr}), KEY_W'({1'b1, g, rc}));
  endtask

  task automatic expect_core(input string req, input bit v, input logic [2:0] op,
                             input logic [KEY_W-1:0] key);
    chk(s_cv == v && s_co == op && s_ck == key, req, s_ck, key);
  endtask

  task automatic t_reset();
    chk(rsp_valid == 0 && core_valid == 0 && core_key == '0, "R1 reset outputs",
        KEY_W'({rsp_valid, core_valid}), '0);
    issue(3'd0, 0, 0, 0, '0, '0);
    expect_rsp("R1 empty after reset", 0, 3'd1);
    expect_core("R2 no key on deny", 0, 3'd0, '0);
    @(negedge clk);
    chk(rsp_valid == 0, "R11 single-cycle response", KEY_W'(rsp_valid), '0);
  endtask

  task automatic t_import();
    lc_state = 2'd2;
    issue(3'd4, 1, 0, 0, K1, 8'h29);
    expect_rsp("R5 lifecycle deny", 0, 3'd3);
    issue(3'd0, 1, 0, 0, '0, '0);
    expect_rsp("R9 slot still empty after denied import", 0, 3'd1);
    lc_state = 2'd0;
    issue(3'd4, 1, 0, 0, K1, 8'h29);
    expect_rsp("R5 import grant", 1, 3'd0);
    expect_core("R2 import does not expose key", 0, 3'd0, '0);
    issue(3'd4, 1, 0, 0, K2, 8'hFF);
    expect_rsp("R5 import into populated slot", 0, 3'd2);
    issue(3'd4, 15, 0, 0, K2, 8'h01);
    expect_rsp("R5 slot without import flag", 0, 3'd2);
  endtask

  task automatic t_use();
    issue(3'd0, 1, 0, 0, '0, '0);
    expect_rsp("R3 encrypt grant", 1, 3'd0);
    expect_core("R3 encrypt key on core port", 1, 3'd0, K1);
    issue(3'd1, 1, 0, 0, '0, '0);
    expect_rsp("R3 decrypt flag clear", 0, 3'd2);
    issue(3'd2, 1, 0, 0, '0, '0);
    expect_rsp("R4 verify-only denies MAC generate", 0, 3'd2);
    expect_core("R2 no key on MAC generate deny", 0, 3'd0, '0);
    issue(3'd3, 1, 0, 0, '0, '0);
    expect_rsp("R4 verify-only grants MAC verify", 1, 3'd0);
    expect_core("R4 verify key", 1, 3'd3, K1);
    issue(3'd7, 1, 0, 0, '0, '0);
    expect_rsp("R12 reserved op", 0, 3'd2);
  endtask

  task automatic t_update();
    issue(3'd5, 1, 0, 0, K2, 8'h21);
    expect_rsp("R6 update without proof", 0, 3'd4);
    issue(3'd0, 1, 0, 0, '0, '0);
    expect_core("R9 key unchanged after denied update", 1, 3'd0, K1);
    issue(3'd5, 4, 0, 1, K2, 8'h21);
    expect_rsp("R6 update on empty slot", 0, 3'd1);
    @(negedge clk);
    put(3'd5, 1, 0, 1, K2, 8'h21);
    @(negedge clk);
    sample();
    expect_rsp("R6 update grant", 1, 3'd0);
    put(3'd0, 1, 0, 0, '0, '0);
    @(negedge clk);
    req_valid = 1'b0;
    sample();
    expect_core("R6 back-to-back use sees new key", 1, 3'd0, K2);
    issue(3'd3, 1, 0, 0, '0, '0);
    expect_rsp("R6 new flags drop MAC verify", 0, 3'd2);
  endtask

  task automatic t_export();
    lc_state = 2'd1;
    issue(3'd4, 2, 0, 0, K3, 8'h41);
    expect_rsp("R5 import in second allowed lifecycle", 1, 3'd0);
    issue(3'd6, 2, 1, 0, '0, '0);
    expect_rsp("R8 wrapped export grant", 1, 3'd0);
    expect_core("R8 export key on core port", 1, 3'd6, K3);
    issue(3'd6, 2, 0, 0, '0, '0);
    expect_rsp("R7 plaintext export denied", 0, 3'd5);
    expect_core("R2 no key on plaintext export", 0, 3'd0, '0);
    issue(3'd6, 5, 0, 0, '0, '0);
    expect_rsp("R7 plaintext beats empty", 0, 3'd5);
    issue(3'd4, 3, 0, 0, K4, 8'hE0);
    expect_rsp("R5 import locked slot", 1, 3'd0);
    issue(3'd6, 3, 1, 0, '0, '0);
    expect_rsp("R8 export lock overrides export flag", 0, 3'd2);
    issue(3'd5, 3, 0, 1, K1, 8'h60);
    expect_rsp("R10 update grant on locked slot", 1, 3'd0);
    issue(3'd6, 3, 1, 0, '0, '0);
    expect_rsp("R10 lock survives update", 0, 3'd2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (!req_ready) @(negedge clk);
    t_reset();
    t_import();
    t_use();
    t_update();
    t_export();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule